// File: doc/BRIEF.md
# A32 Immediate-Operand Data-Processing Decoder

This block takes one 32-bit A32 instruction word per transfer and breaks it
into the fields of the data-processing class that uses an immediate second
operand. It tells whether the word belongs to that class and gives the
condition, operation code, flag-update bit and the two register numbers. It
also marks the subtract operation on its own output. It rebuilds the full
32-bit operand from the 8-bit value and the rotate field. It decodes only
this one class. It does not evaluate conditions and does not execute anything.

Words come in on a valid/ready stream and leave on a second valid/ready
stream, one result per accepted word, in order. A word moves on any cycle
with `in_valid` and `in_ready` both high. A result moves on any cycle with
`out_valid` and `out_ready` both high. By default (`OUT_REG = 1`) one
register stage sits between the two streams, and it accepts a new word
whenever it is empty or its result leaves in the same cycle. While
`out_ready` is low, the held result and `out_valid` stay unchanged. With
`OUT_REG = 0` the decode is purely combinational and `in_ready` follows
`out_ready`.

Top module: `a32dp_decoder`

## Requirements
- R1: `out_hit` is 1 exactly when bits 27:25 of the accepted word equal 3'b001. No other bit takes part in the class decision.
- R2: For a class word, `out_cond` equals bits 31:28. The value 4'hE is the always-execute code and is passed through like any other.
- R3: For a class word, `out_opcode` equals bits 24:21. `out_is_sub` is 1 exactly when that field is 4'b0010.
- R4: For a class word, `out_setflags` equals bit 20. A 1 means the flag-updating form.
- R5: For a class word, `out_rn` equals bits 19:16 (first operand) and `out_rd` equals bits 15:12 (destination).
- R6: For a class word, `out_imm` is the zero-extended bits 7:0 rotated right, within 32 bits, by twice the value of bits 11:8.
- R7: A rotate field of 0 gives bits 7:0 zero-extended, with no rotation.
- R8: For a word outside the class, `out_hit` is 0 and every other decoded output is 0.
- R9: Each accepted word gives exactly one result, in order. With `OUT_REG = 1` the result is offered the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs hold. After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: Word 32'hE2433C72 decodes as subtract, first operand 3, destination 3, flags not updated, operand 32'h00007200 (rotate amount 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take the word |
| in_word | input | 32 | A32 instruction word |
| out_valid | output | 1 | Decoded result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Word is data-processing with immediate operand |
| out_cond | output | 4 | Condition field |
| out_opcode | output | 4 | Operation code |
| out_setflags | output | 1 | Flag-update bit |
| out_is_sub | output | 1 | Operation is subtract |
| out_rn | output | 4 | First operand register |
| out_rd | output | 4 | Destination register |
| out_imm | output | 32 | Rebuilt 32-bit immediate operand |

## Verification
Every one of the sixteen rotate amounts is tried with random 8-bit values and
with the all-ones and end-bit patterns 8'hFF and 8'h81. Those patterns show
whether bits that wrap past bit 0 come back in at the top, and whether the
amount is doubled. The known subtract word, its flag-setting twin, and random
words whose class bits are forced away from 001 separate class detection and
zeroing from field extraction. A phase with random stalls on the output side
shows whether results are lost, duplicated or reordered under back-pressure.

// File: rtl/a32dp_pkg.sv
package a32dp_pkg;
  localparam int WORD_W  = 32;
  localparam int COND_W  = 4;
  localparam int OPC_W   = 4;
  localparam int REG_W   = 4;
  localparam int ROT_W   = 4;
  localparam int IMM8_W  = 8;
  localparam int NROT    = 1 << ROT_W;

  // bit positions the class decision and the fields depend on
  localparam int COND_LSB = 28;
  localparam int CLS_LSB  = 25;
  localparam int OPC_LSB  = 21;
  localparam int S_BIT    = 20;
  localparam int RN_LSB   = 16;
  localparam int RD_LSB   = 12;
  localparam int ROT_LSB  = 8;

  localparam logic [2:0]       CLASS_DPI = 3'b001;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0010;

  typedef struct packed {
    logic              hit;
    logic [COND_W-1:0] cond;
    logic [OPC_W-1:0]  opcode;
    logic              setflags;
    logic              is_sub;
    logic [REG_W-1:0]  rn;
    logic [REG_W-1:0]  rd;
    logic [WORD_W-1:0] imm;
  } dp_fields_t;

  localparam int FIELDS_W = $bits(dp_fields_t);
endpackage

// File: rtl/a32dp_field_split.sv
module a32dp_field_split
  import a32dp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic [COND_W-1:0] cond,
  output logic [OPC_W-1:0]  opcode,
  output logic              setflags,
  output logic              is_sub,
  output logic [REG_W-1:0]  rn,
  output logic [REG_W-1:0]  rd,
  output logic [ROT_W-1:0]  rot,
  output logic [IMM8_W-1:0] imm8
);
  always_comb begin
    hit      = (word[CLS_LSB +: 3] == CLASS_DPI);
    cond     = '0;
    opcode   = '0;
    setflags = 1'b0;
    is_sub   = 1'b0;
    rn       = '0;
    rd       = '0;
    rot      = '0;
    imm8     = '0;
    if (hit) begin
      cond     = word[COND_LSB +: COND_W];
      opcode   = word[OPC_LSB +: OPC_W];
      setflags = word[S_BIT];
      is_sub   = (word[OPC_LSB +: OPC_W] == OPC_SUB);
      rn       = word[RN_LSB +: REG_W];
      rd       = word[RD_LSB +: REG_W];
      rot      = word[ROT_LSB +: ROT_W];
      imm8     = word[IMM8_W-1:0];
    end
  end

  // R8: outside the class nothing leaks out of the splitter
  always_comb begin
    if (!hit) begin
      p_split_zero_r8: assert ({cond, opcode, setflags, is_sub, rn, rd, rot, imm8} == '0)
        else $error("split fields not zero for non-class word");
    end
  end
endmodule

// File: rtl/a32dp_imm_expand.sv
module a32dp_imm_expand
  import a32dp_pkg::*;
(
  input  logic [ROT_W-1:0]  rot,
  input  logic [IMM8_W-1:0] imm8,
  output logic [WORD_W-1:0] imm32
);
  localparam int ZEXT = WORD_W - IMM8_W;

  logic [WORD_W-1:0]   base;
  logic [2*WORD_W-1:0] twice;
  logic [WORD_W-1:0]   cand [NROT];

  assign base  = {{ZEXT{1'b0}}, imm8};
  assign twice = {base, base};

  // one candidate per rotate value; right rotation by 2*k
  for (genvar k = 0; k < NROT; k++) begin : g_rot
    localparam int SH = (2 * k) % WORD_W;
    assign cand[k] = twice[SH +: WORD_W];
  end

  assign imm32 = cand[rot];

  always_comb begin
    // R7: a zero rotate leaves the value zero-extended
    if (rot == '0) begin
      p_zero_rot_r7: assert (imm32 == {{ZEXT{1'b0}}, imm8})
        else $error("rotate 0 altered the immediate");
    end
    // R6: a rotation neither adds nor drops set bits
    p_popcount_r6: assert ($countones(imm32) == $countones(imm8))
      else $error("rotation changed the number of set bits");
  end
endmodule

// File: rtl/a32dp_out_stage.sv
module a32dp_out_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (OUT_REG) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end

    // R9: a stalled result holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data))
      else $error("result changed under back-pressure");

    // R9: an accepted word is offered on the next cycle
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid)
      else $error("accepted word not offered");
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/a32dp_decoder.sv
module a32dp_decoder
  import a32dp_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [COND_W-1:0] out_cond,
  output logic [OPC_W-1:0]  out_opcode,
  output logic              out_setflags,
  output logic              out_is_sub,
  output logic [REG_W-1:0]  out_rn,
  output logic [REG_W-1:0]  out_rd,
  output logic [WORD_W-1:0] out_imm
);
  dp_fields_t        dec, res;
  logic [ROT_W-1:0]  rot;
  logic [IMM8_W-1:0] imm8;

  a32dp_field_split u_split (
    .word     (in_word),
    .hit      (dec.hit),
    .cond     (dec.cond),
    .opcode   (dec.opcode),
    .setflags (dec.setflags),
    .is_sub   (dec.is_sub),
    .rn       (dec.rn),
    .rd       (dec.rd),
    .rot      (rot),
    .imm8     (imm8)
  );

  a32dp_imm_expand u_expand (
    .rot   (rot),
    .imm8  (imm8),
    .imm32 (dec.imm)
  );

  a32dp_out_stage #(.W(FIELDS_W), .OUT_REG(OUT_REG)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (dec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res)
  );

  assign out_hit      = res.hit;
  assign out_cond     = res.cond;
  assign out_opcode   = res.opcode;
  assign out_setflags = res.setflags;
  assign out_is_sub   = res.is_sub;
  assign out_rn       = res.rn;
  assign out_rd       = res.rd;
  assign out_imm      = res.imm;

  // R3: the subtract mark only accompanies a class word with the subtract code
  p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_sub |-> out_hit && out_opcode == OPC_SUB)
    else $error("subtract mark without subtract opcode");

  // R8: an offered non-class result carries all-zero fields
  p_nonhit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_cond == '0 && out_opcode == '0 && !out_setflags
      && !out_is_sub && out_rn == '0 && out_rd == '0 && out_imm == '0)
    else $error("non-class result has non-zero fields");
endmodule

// File: tb/a32dp_decoder_tb.sv
`timescale 1ns/1ps
module a32dp_decoder_tb;
  typedef struct {
    logic [31:0] word;
    logic        hit;
    logic [3:0]  cond, opcode, rn, rd;
    logic        s, sub;
    logic [31:0] imm;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit, out_setflags, out_is_sub;
  logic [3:0]  out_cond, out_opcode, out_rn, out_rd;
  logic [31:0] out_imm;

  int total = 0, bad = 0, n_sent = 0, n_recv = 0;
  bit bp_mode = 1'b0, finished = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  a32dp_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_cond(out_cond), .out_opcode(out_opcode),
    .out_setflags(out_setflags), .out_is_sub(out_is_sub),
    .out_rn(out_rn), .out_rd(out_rd), .out_imm(out_imm)
  );

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [31:0] x;
    e = '{word: w, hit: 1'b0, cond: '0, opcode: '0, rn: '0, rd: '0,
          s: 1'b0, sub: 1'b0, imm: '0};
    if (w[27:25] == 3'b001) begin            // R1 class code
      e.hit    = 1'b1;
      e.cond   = w[31:28];
      e.opcode = w[24:21];
      e.sub    = (w[24:21] == 4'b0010);
      e.s      = w[20];
      e.rn     = w[19:16];
      e.rd     = w[15:12];
      x = {24'h0, w[7:0]};
      for (int i = 0; i < 2 * int'(w[11:8]); i++) x = {x[0], x[31:1]};
      e.imm = x;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                     input logic [31:0] w);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s word=%h actual=%h expected=%h", tag, w, got, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: called at posedge+1
  task automatic send(input logic [31:0] w);
    in_word  = w;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    q.push_back(model(w));
    n_sent++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] cls_word(input logic [3:0] rot, input logic [7:0] v);
    logic [31:0] r;
    r = $urandom;
    r[27:25] = 3'b001;
    r[11:8]  = rot;
    r[7:0]   = v;
    return r;
  endfunction

  // monitor / scoreboard
  initial begin
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        n_recv++;
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 unexpected result actual=1 expected=0");
        end else begin
          e = q.pop_front();
          chk("R1 hit", {31'h0, out_hit}, {31'h0, e.hit}, e.word);
          if (e.hit) begin
            chk("R2 cond", {28'h0, out_cond}, {28'h0, e.cond}, e.word);
            chk("R3 opcode", {28'h0, out_opcode}, {28'h0, e.opcode}, e.word);
            chk("R3 is_sub", {31'h0, out_is_sub}, {31'h0, e.sub}, e.word);
            chk("R4 setflags", {31'h0, out_setflags}, {31'h0, e.s}, e.word);
            chk("R5 rn/rd", {24'h0, out_rn, out_rd}, {24'h0, e.rn, e.rd}, e.word);
            t = (e.word[11:8] == 4'h0) ? "R7 imm zero rotate" : "R6 imm";
            chk(t, out_imm, e.imm, e.word);
          end else begin
            chk("R8 zero fields",
                {out_cond, out_opcode, out_rn, out_rd, 14'h0, out_setflags, out_is_sub},
                32'h0, e.word);
            chk("R8 zero imm", out_imm, 32'h0, e.word);
          end
          if (e.word == 32'hE2433C72) begin
            // R10: known subtract word with fixed expectations
            chk("R10 example", {out_is_sub, out_setflags, 6'h0, out_rn, out_rd, 16'h0},
                {1'b1, 1'b0, 6'h0, 4'd3, 4'd3, 16'h0}, e.word);
            chk("R10 example imm", out_imm, 32'h0000_7200, e.word);
          end
        end
      end
    end
  end

  // output-side readiness
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", {31'h0, out_valid}, 32'h0, 32'h0);
    chk("R9 reset in_ready", {31'h0, in_ready}, 32'h1, 32'h0);
    @(posedge clk); #1;

    send(32'hE2433C72);               // R10
    send(32'hE2533C72);               // R4 flag-setting form
    send(32'h12433C72);               // R2 other condition

    // R6/R7 sweep of every rotate amount
    for (int r = 0; r < 16; r++) begin
      send(cls_word(4'(r), 8'hFF));
      send(cls_word(4'(r), 8'h81));
      for (int k = 0; k < 3; k++) send(cls_word(4'(r), 8'($urandom)));
    end

    // R8 words outside the class
    for (int k = 0; k < 30; k++) begin
      w = $urandom;
      if (w[27:25] == 3'b001) w[27] = 1'b1;
      send(w);
    end

    // R9 back-pressure phase with mixed words
    bp_mode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      w = $urandom;
      if (k % 2 == 0) w[27:25] = 3'b001;
      send(w);
    end
    bp_mode = 1'b0;

    for (int k = 0; k < 200 && q.size() != 0; k++) @(posedge clk);
    #1;
    chk("R9 results match accepted words", n_recv, n_sent, 32'h0);
    finished = 1'b1;
    summary();
  end
endmodule